// File: doc/BRIEF.md
# Interleaving Flash Command Scheduler

This block sits between the address-translation stage of a flash storage controller and one module of the flash array. It accepts flash commands (read, program, erase) that already name a target super-chip, super-block and super-page, and it sends them to a single shared flash command bus. It does not wait for one command to finish before sending the next. A long erase on one super-chip therefore overlaps with reads and programs on the other super-chips of the same module.

The scheduler keeps one busy flag and one outstanding tag for each super-chip. Incoming commands wait in a small age-ordered pending queue. On every bus slot the oldest queued command whose super-chip is idle goes out. This can reorder work across super-chips while keeping each super-chip's own stream in order. When no queued command can go, the slot carries a status check to one of the busy super-chips, chosen round-robin. A status check that comes back done frees that super-chip and raises a completion pulse that carries the finished command's tag.

Top module: `fsched_agent`

## Requirements
- R1: After reset, `bus_valid` and `cpl_valid` are low and `cmd_ready` is high.
- R2: Take a command accepted at clock edge k (`cmd_valid` and `cmd_ready` both high) whose super-chip is idle when it becomes the oldest eligible entry. It is driven on the bus after edge k+1, even while other super-chips are busy and waiting to be polled.
- R3: Only one command per super-chip is outstanding at a time. A command for a busy super-chip stays queued until that super-chip's completion.
- R4: A younger command for an idle super-chip is issued ahead of an older command that is waiting on a busy super-chip.
- R5: Commands for the same super-chip are issued, and complete, in their arrival order.
- R6: A status check (`bus_op` = 3) goes on the bus only in a slot where no queued command can be issued, and only to a busy super-chip. Busy super-chips are polled round-robin, starting from the super-chip after the one polled last.
- R7: A status check seen in a cycle with `stat_done` high produces, after the next edge, a one-cycle `cpl_valid` with that super-chip's number and the outstanding tag. A command queued for that super-chip may be issued at that same edge.
- R8: `cmd_ready` is low while the pending queue holds 8 entries, and no command is taken while it is low.
- R9: Opcodes on both the command input and the bus are read = 0, program = 1, erase = 2; the bus uses 3 for status check. An issued command carries its own opcode, super-chip, super-block, super-page and tag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Queue can take a command |
| cmd_op | input | 2 | Command opcode (0 read, 1 program, 2 erase) |
| cmd_chip | input | 2 | Target super-chip |
| cmd_blk | input | 12 | Target super-block |
| cmd_page | input | 8 | Target super-page |
| cmd_tag | input | 6 | Command identifier returned on completion |
| bus_valid | output | 1 | Bus slot carries an operation |
| bus_op | output | 2 | Bus opcode (0..2 as input, 3 status check) |
| bus_chip | output | 2 | Super-chip addressed by the slot |
| bus_blk | output | 12 | Super-block of an issued command |
| bus_page | output | 8 | Super-page of an issued command |
| bus_tag | output | 6 | Tag of an issued command |
| stat_done | input | 1 | Controller answer to the status check in this cycle: operation finished |
| cpl_valid | output | 1 | Completion pulse |
| cpl_tag | output | 6 | Tag of the completed command |
| cpl_chip | output | 2 | Super-chip that completed |

## Verification
A command accepted at edge k to an idle super-chip is due on the bus after edge k+1. A completion is due one edge after the status check that saw `stat_done`, and a command queued for the freed super-chip is due on the bus in the same cycle as that completion. The bench counts rising edges, samples every port on the falling edge and records the cycle of each acceptance, issue and completion. It then compares those cycle numbers directly: issue = acceptance + 1, and next same-chip issue = completion cycle. A flash-controller model with fixed per-opcode busy times supplies `stat_done`, so issue order, per-chip completion order and the round-robin choice of polled super-chip are all known in advance.

// File: rtl/fsched_pkg.sv
package fsched_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_PROG  = 2'd1,
      OP_ERASE = 2'd2,
      OP_STAT  = 2'd3
   } fop_e;
endpackage

// File: rtl/fsched_queue.sv
// Age-ordered pending store: index 0 is the oldest entry; removal from any
// slot closes the gap so that age order is kept by position.
module fsched_queue #(
   parameter int DEPTH = 8,
   parameter int EW    = 32,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        push,
   input  logic [EW-1:0]               push_data,
   input  logic                        pop,
   input  logic [IDX_W-1:0]            pop_idx,
   output logic [DEPTH-1:0][EW-1:0]    ent,
   output logic [DEPTH-1:0]            ent_vld,
   output logic                        full,
   output logic [CNT_W-1:0]            cnt
);
   logic [DEPTH-1:0][EW-1:0] nxt;
   logic [CNT_W-1:0]         wr_pos;

   assign wr_pos = cnt - CNT_W'(pop);
   assign full   = (cnt == CNT_W'(DEPTH));

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         nxt[i] = ent[i];
         if (pop && i >= int'(pop_idx))
            nxt[i] = (i < DEPTH - 1) ? ent[(i < DEPTH - 1) ? i + 1 : i] : '0;
         if (push && wr_pos == CNT_W'(i))
            nxt[i] = push_data;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_vld
      assign ent_vld[g] = (CNT_W'(g) < cnt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent <= '0;
         cnt <= '0;
      end else begin
         ent <= nxt;
         cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
      end
   end
endmodule

// File: rtl/fsched_pick.sv
// Chooses the oldest queued command whose super-chip is idle, and the next
// busy super-chip to poll in round-robin order from rr_ptr.
module fsched_pick #(
   parameter int DEPTH     = 8,
   parameter int NUM_CHIPS = 4,
   localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CHIP_W = $clog2(NUM_CHIPS)
) (
   input  logic [DEPTH-1:0][CHIP_W-1:0] ent_chip,
   input  logic [DEPTH-1:0]             ent_vld,
   input  logic [NUM_CHIPS-1:0]         busy,
   input  logic [CHIP_W-1:0]            rr_ptr,
   output logic                         iss_hit,
   output logic [IDX_W-1:0]             iss_idx,
   output logic                         poll_hit,
   output logic [CHIP_W-1:0]            poll_chip
);
   logic [CHIP_W-1:0] cand;

   always_comb begin
      iss_hit = 1'b0;
      iss_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (ent_vld[i] && !busy[ent_chip[i]]) begin
            iss_hit = 1'b1;
            iss_idx = IDX_W'(i);
         end
      end
   end

   always_comb begin
      poll_hit  = 1'b0;
      poll_chip = '0;
      cand      = '0;
      for (int k = NUM_CHIPS - 1; k >= 0; k--) begin
         cand = rr_ptr + CHIP_W'(k);
         if (busy[cand]) begin
            poll_hit  = 1'b1;
            poll_chip = cand;
         end
      end
   end
endmodule

// File: rtl/fsched_agent.sv
module fsched_agent #(
   parameter int NUM_CHIPS = 4,
   parameter int QDEPTH    = 8,
   parameter int TAG_W     = 6,
   parameter int BLK_W     = 12,
   parameter int PG_W      = 8,
   localparam int CHIP_W   = $clog2(NUM_CHIPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [1:0]        cmd_op,
   input  logic [CHIP_W-1:0] cmd_chip,
   input  logic [BLK_W-1:0]  cmd_blk,
   input  logic [PG_W-1:0]   cmd_page,
   input  logic [TAG_W-1:0]  cmd_tag,
   output logic              bus_valid,
   output logic [1:0]        bus_op,
   output logic [CHIP_W-1:0] bus_chip,
   output logic [BLK_W-1:0]  bus_blk,
   output logic [PG_W-1:0]   bus_page,
   output logic [TAG_W-1:0]  bus_tag,
   input  logic              stat_done,
   output logic              cpl_valid,
   output logic [TAG_W-1:0]  cpl_tag,
   output logic [CHIP_W-1:0] cpl_chip
);
   import fsched_pkg::*;

   localparam int PG_LSB   = TAG_W;
   localparam int BLK_LSB  = PG_LSB + PG_W;
   localparam int CHIP_LSB = BLK_LSB + BLK_W;
   localparam int OP_LSB   = CHIP_LSB + CHIP_W;
   localparam int EW       = OP_LSB + 2;
   localparam int IDX_W    = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
   localparam int CNT_W    = $clog2(QDEPTH + 1);

   if (NUM_CHIPS < 2 || (NUM_CHIPS & (NUM_CHIPS - 1)) != 0) begin : g_bad_chips
      $error("fsched_agent: NUM_CHIPS must be a power of two, at least 2");
   end
   if (QDEPTH < 2) begin : g_bad_depth
      $error("fsched_agent: QDEPTH must be at least 2");
   end

   logic [QDEPTH-1:0][EW-1:0]     ent;
   logic [QDEPTH-1:0][CHIP_W-1:0] ent_chip;
   logic [QDEPTH-1:0]             ent_vld;
   logic                          q_full;
   logic [CNT_W-1:0]              q_cnt;
   logic                          iss_hit, poll_hit;
   logic [IDX_W-1:0]              iss_idx;
   logic [CHIP_W-1:0]             poll_chip, rr_q, sel_chip;
   logic [EW-1:0]                 sel;
   logic [NUM_CHIPS-1:0]          busy_q, busy_eff, clr, set;
   logic [TAG_W-1:0]              tag_q [NUM_CHIPS];
   logic                          poll_answered;

   assign cmd_ready = !q_full;

   fsched_queue #(.DEPTH(QDEPTH), .EW(EW)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (cmd_valid && cmd_ready),
      .push_data ({cmd_op, cmd_chip, cmd_blk, cmd_page, cmd_tag}),
      .pop       (iss_hit),
      .pop_idx   (iss_idx),
      .ent       (ent),
      .ent_vld   (ent_vld),
      .full      (q_full),
      .cnt       (q_cnt)
   );

   for (genvar g = 0; g < QDEPTH; g++) begin : g_chip_field
      assign ent_chip[g] = ent[g][CHIP_LSB +: CHIP_W];
   end

   // A status check answered done in this slot frees its chip at this edge.
   assign poll_answered = bus_valid && (bus_op == OP_STAT) && stat_done;

   always_comb begin
      clr = '0;
      if (poll_answered) clr[bus_chip] = 1'b1;
   end
   assign busy_eff = busy_q & ~clr;

   fsched_pick #(.DEPTH(QDEPTH), .NUM_CHIPS(NUM_CHIPS)) u_pick (
      .ent_chip  (ent_chip),
      .ent_vld   (ent_vld),
      .busy      (busy_eff),
      .rr_ptr    (rr_q),
      .iss_hit   (iss_hit),
      .iss_idx   (iss_idx),
      .poll_hit  (poll_hit),
      .poll_chip (poll_chip)
   );

   assign sel      = ent[iss_idx];
   assign sel_chip = sel[CHIP_LSB +: CHIP_W];

   always_comb begin
      set = '0;
      if (iss_hit) set[sel_chip] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= '0;
         rr_q      <= '0;
         bus_valid <= 1'b0;
         bus_op    <= '0;
         bus_chip  <= '0;
         bus_blk   <= '0;
         bus_page  <= '0;
         bus_tag   <= '0;
         cpl_valid <= 1'b0;
         cpl_tag   <= '0;
         cpl_chip  <= '0;
         for (int c = 0; c < NUM_CHIPS; c++) tag_q[c] <= '0;
      end else begin
         busy_q    <= busy_eff | set;
         cpl_valid <= poll_answered;
         if (poll_answered) begin
            cpl_chip <= bus_chip;
            cpl_tag  <= tag_q[bus_chip];
         end
         if (iss_hit) begin
            tag_q[sel_chip] <= sel[TAG_W-1:0];
            bus_valid <= 1'b1;
            bus_op    <= sel[OP_LSB +: 2];
            bus_chip  <= sel_chip;
            bus_blk   <= sel[BLK_LSB +: BLK_W];
            bus_page  <= sel[PG_LSB +: PG_W];
            bus_tag   <= sel[TAG_W-1:0];
         end else if (poll_hit) begin
            bus_valid <= 1'b1;
            bus_op    <= OP_STAT;
            bus_chip  <= poll_chip;
            bus_blk   <= '0;
            bus_page  <= '0;
            bus_tag   <= '0;
            rr_q      <= poll_chip + CHIP_W'(1);
         end else begin
            bus_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/fsched_agent_chk.sv
module fsched_agent_chk #(
   parameter int NUM_CHIPS = 4,
   parameter int QDEPTH    = 8,
   localparam int CHIP_W   = $clog2(NUM_CHIPS),
   localparam int CNT_W    = $clog2(QDEPTH + 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cmd_valid,
   input logic                 cmd_ready,
   input logic [CNT_W-1:0]     q_cnt,
   input logic                 bus_valid,
   input logic [1:0]           bus_op,
   input logic [CHIP_W-1:0]    bus_chip,
   input logic                 stat_done,
   input logic                 cpl_valid,
   input logic [CHIP_W-1:0]    cpl_chip,
   input logic [NUM_CHIPS-1:0] busy_q
);
   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (!bus_valid && !cpl_valid));

   p_no_repeat_chip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_op != 2'd3) |=>
         !(bus_valid && bus_op != 2'd3 && bus_chip == $past(bus_chip)));

   p_poll_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_op == 2'd3) |-> busy_q[bus_chip]);

   p_cpl_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_op == 2'd3 && stat_done) |=>
         (cpl_valid && cpl_chip == $past(bus_chip)));

   p_cpl_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_op == 2'd3 && stat_done) |=>
         (!busy_q[$past(bus_chip)] ||
          (bus_valid && bus_op != 2'd3 && bus_chip == $past(bus_chip))));

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (q_cnt <= $past(q_cnt)));

   p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      q_cnt <= CNT_W'(QDEPTH));
endmodule

bind fsched_agent fsched_agent_chk #(.NUM_CHIPS(NUM_CHIPS), .QDEPTH(QDEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .q_cnt     (q_cnt),
   .bus_valid (bus_valid),
   .bus_op    (bus_op),
   .bus_chip  (bus_chip),
   .stat_done (stat_done),
   .cpl_valid (cpl_valid),
   .cpl_chip  (cpl_chip),
   .busy_q    (busy_q)
);

// File: tb/sim_fsched_agent.sv
module sim_fsched_agent;
   localparam int CLK_P = 10;
   localparam int NCH   = 4;
   localparam int TW    = 6;
   localparam int NT    = 64;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       cmd_valid = 1'b0, cmd_ready;
   logic [1:0] cmd_op = '0;
   logic [1:0] cmd_chip = '0;
   logic [11:0] cmd_blk = '0;
   logic [7:0]  cmd_page = '0;
   logic [TW-1:0] cmd_tag = '0;
   logic       bus_valid;
   logic [1:0] bus_op, bus_chip;
   logic [11:0] bus_blk;
   logic [7:0]  bus_page;
   logic [TW-1:0] bus_tag, cpl_tag;
   logic       stat_done, cpl_valid;
   logic [1:0] cpl_chip;

   fsched_agent u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_chip(cmd_chip), .cmd_blk(cmd_blk), .cmd_page(cmd_page),
      .cmd_tag(cmd_tag), .bus_valid(bus_valid), .bus_op(bus_op), .bus_chip(bus_chip),
      .bus_blk(bus_blk), .bus_page(bus_page), .bus_tag(bus_tag), .stat_done(stat_done),
      .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_chip(cpl_chip)
   );

   always #(CLK_P / 2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0, n_bad = 0;

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // Flash-controller model: fixed busy time per opcode.
   function automatic int dur(logic [1:0] op);
      case (op)
         2'd0:    return 3;
         2'd1:    return 10;
         default: return 40;
      endcase
   endfunction

   int rem [NCH];
   initial for (int c = 0; c < NCH; c++) rem[c] = 0;
   always @(posedge clk) begin
      for (int c = 0; c < NCH; c++) begin
         if (bus_valid && bus_op != 2'd3 && int'(bus_chip) == c) rem[c] <= dur(bus_op);
         else if (rem[c] > 0) rem[c] <= rem[c] - 1;
      end
   end
   assign stat_done = bus_valid && (bus_op == 2'd3) && (rem[bus_chip] == 0);

   // Scoreboard state
   int exp_iss [$];
   int exp_cpl [NCH][$];
   bit out [NCH];
   int out_tag [NCH];
   int acc_cyc [NT], iss_cyc [NT], cpl_cyc [NT];
   int exp_op [NT], exp_blk [NT], exp_pg [NT], exp_chip [NT];
   int last_poll = -1;
   int e, nx;

   initial for (int c = 0; c < NCH; c++) begin out[c] = 0; out_tag[c] = 0; end

   always @(negedge clk) begin
      if (rst_n) begin
         if (cpl_valid) begin
            check(out[cpl_chip] && out_tag[cpl_chip] == int'(cpl_tag),
                  "R7 completion names the outstanding tag", int'(cpl_tag), out_tag[cpl_chip]);
            if (exp_cpl[cpl_chip].size() > 0) begin
               e = exp_cpl[cpl_chip].pop_front();
               check(int'(cpl_tag) == e, "R5 per-chip completion order", int'(cpl_tag), e);
            end else check(1'b0, "R7 unexpected completion", int'(cpl_tag), -1);
            cpl_cyc[cpl_tag] = cyc;
            out[cpl_chip] = 0;
         end
         if (bus_valid && bus_op == 2'd3) begin
            check(out[bus_chip], "R6 poll targets a busy chip", int'(bus_chip), -1);
            if (last_poll >= 0) begin
               nx = last_poll;
               for (int k = NCH; k >= 1; k--)
                  if (out[(last_poll + k) % NCH]) nx = (last_poll + k) % NCH;
               check(int'(bus_chip) == nx, "R6 round-robin poll order", int'(bus_chip), nx);
            end
            last_poll = int'(bus_chip);
         end
         if (bus_valid && bus_op != 2'd3) begin
            check(!out[bus_chip], "R3 one outstanding command per chip", int'(bus_tag), out_tag[bus_chip]);
            if (exp_iss.size() > 0) begin
               e = exp_iss.pop_front();
               check(int'(bus_tag) == e, "R4 issue order", int'(bus_tag), e);
            end else check(1'b0, "R4 unexpected issue", int'(bus_tag), -1);
            check(int'(bus_op) == exp_op[bus_tag], "R9 opcode carried", int'(bus_op), exp_op[bus_tag]);
            check(int'(bus_chip) == exp_chip[bus_tag] && int'(bus_blk) == exp_blk[bus_tag]
                  && int'(bus_page) == exp_pg[bus_tag],
                  "R9 address fields carried", int'(bus_blk), exp_blk[bus_tag]);
            iss_cyc[bus_tag] = cyc;
            out[bus_chip] = 1;
            out_tag[bus_chip] = int'(bus_tag);
         end
      end
   end

   task automatic send(int op, int chip, int tag);
      exp_op[tag] = op; exp_chip[tag] = chip;
      exp_blk[tag] = 100 + tag * 7; exp_pg[tag] = (tag * 3) % 256;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'(op); cmd_chip = 2'(chip);
      cmd_blk = 12'(exp_blk[tag]); cmd_page = 8'(exp_pg[tag]); cmd_tag = TW'(tag);
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      acc_cyc[tag] = cyc;
      cmd_valid = 1'b0;
   endtask

   function automatic bit pending();
      bit p = (exp_iss.size() != 0);
      for (int c = 0; c < NCH; c++) p = p || out[c] || (exp_cpl[c].size() != 0);
      return p;
   endfunction

   task automatic drain(string req);
      int n = 0;
      while (pending() && n < 3000) begin @(negedge clk); n++; end
      check(n < 3000, req, n, 3000);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!bus_valid, "R1 bus idle after reset", int'(bus_valid), 0);
      check(!cpl_valid, "R1 no completion after reset", int'(cpl_valid), 0);
      check(cmd_ready, "R1 ready after reset", int'(cmd_ready), 1);

      // Erase on chip 0, then chip 0 read queued behind it, reads/programs to others.
      exp_iss = '{1, 3, 4, 2};
      exp_cpl[0].push_back(1); exp_cpl[0].push_back(2);
      exp_cpl[1].push_back(3); exp_cpl[2].push_back(4);
      send(2, 0, 1);
      send(0, 0, 2);
      send(0, 1, 3);
      send(1, 2, 4);
      drain("R4 first pattern drains");
      check(iss_cyc[1] == acc_cyc[1] + 1, "R2 erase issue latency", iss_cyc[1], acc_cyc[1] + 1);
      check(iss_cyc[3] == acc_cyc[3] + 1, "R2 read issue latency while chip 0 busy", iss_cyc[3], acc_cyc[3] + 1);
      check(iss_cyc[4] == acc_cyc[4] + 1, "R2 program issue latency", iss_cyc[4], acc_cyc[4] + 1);
      check(iss_cyc[2] > iss_cyc[4], "R4 younger command overtakes", iss_cyc[2], iss_cyc[4] + 1);
      check(iss_cyc[2] == cpl_cyc[1], "R7 freed chip issues in completion cycle", iss_cyc[2], cpl_cyc[1]);

      // Fill the queue behind a long erase, then a command for an idle chip.
      exp_iss = '{10, 11, 19, 12, 13, 14, 15, 16, 17, 18};
      for (int t = 10; t <= 18; t++) exp_cpl[0].push_back(t);
      exp_cpl[1].push_back(19);
      send(2, 0, 10);
      for (int t = 11; t <= 18; t++) send(0, 0, t);
      check(!cmd_ready, "R8 backpressure with 8 queued", int'(cmd_ready), 0);
      send(0, 1, 19);
      check(acc_cyc[19] > iss_cyc[11], "R8 held until a slot frees", acc_cyc[19], iss_cyc[11] + 1);
      drain("R5 same-chip stream drains");
      check(iss_cyc[19] == acc_cyc[19] + 1, "R2 issue latency after backpressure", iss_cyc[19], acc_cyc[19] + 1);
      check(iss_cyc[12] == cpl_cyc[11], "R7 next same-chip read in completion cycle", iss_cyc[12], cpl_cyc[11]);
      check(iss_cyc[18] > iss_cyc[17], "R5 arrival order on one chip", iss_cyc[18], iss_cyc[17] + 1);

      // All four chips busy: round-robin polling, mixed opcodes.
      exp_iss = '{30, 31, 32, 33, 34};
      exp_cpl[0].push_back(30); exp_cpl[1].push_back(31);
      exp_cpl[2].push_back(32); exp_cpl[3].push_back(33);
      exp_cpl[3].push_back(34);
      send(2, 0, 30);
      send(1, 1, 31);
      send(2, 2, 32);
      send(0, 3, 33);
      send(1, 3, 34);
      drain("R6 four-chip pattern drains");
      check(iss_cyc[34] == cpl_cyc[33], "R7 chip 3 reuse in completion cycle", iss_cyc[34], cpl_cyc[33]);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog R1-all: actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule